// File: doc/BRIEF.md
# Counter Overflow Status Aggregator

This block collects the sticky overflow flags of the programmable event counters (counters 3 to 31) into one 32-bit read-only overflow view for supervisor-level software. Each view bit is masked according to the current privilege mode. In machine and supervisor mode, a bit shows only when the machine counter-enable bit for that counter is set. In virtual supervisor mode, the hypervisor counter-enable bit for that counter must also be set. The user modes see nothing.

The block also holds the single local count-overflow interrupt pending bit that all counters share. This bit feeds position 13 of the interrupt-pending register. An overflow request from any counter sets it. Software can write it at any time, and it normally clears the bit before it services the interrupt. When the overflow-interrupt feature is configured out, the pending bit is tied to zero.

Top module: `ovf_view_agg`

## Requirements
- R1: With privilege code 3'b011 (machine) and every machine enable bit set, view bit X equals the overflow flag of counter X for every X from 3 to 31.
- R2: In machine (3'b011) or supervisor (3'b001) mode, view bit X equals flag X AND machine enable bit X.
- R3: In virtual supervisor mode (3'b101), view bit X equals flag X AND machine enable bit X AND hypervisor enable bit X.
- R4: In user (3'b000), virtual user (3'b100) and every unassigned privilege code (3'b010, 3'b110, 3'b111), the whole view reads 0.
- R5: View bits 0 to 2 always read 0.
- R6: A request pulse from any counter sets the pending bit at the next rising clock edge.
- R7: A software write loads the written value into the pending bit at the next rising clock edge, so writing 0 clears it and writing 1 sets it.
- R8: When a software write of 0 and a counter request occur in the same cycle, the pending bit is 1 afterwards.
- R9: Reset clears the pending bit, and the bit holds its value in cycles with neither a write nor a request.
- R10: When the overflow-interrupt feature is configured out (HAS_LCOF = 0), the pending bit is 0 whatever the requests and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 3 | Current privilege: {virtualized, level[1:0]} |
| of_flags | input | 29 | Sticky overflow flag of counters 3..31 (index = counter number) |
| ovf_req | input | 29 | One-cycle overflow interrupt request from counters 3..31 |
| mctr_en | input | 29 | Machine counter-enable bits 3..31 |
| hctr_en | input | 29 | Hypervisor counter-enable bits 3..31 |
| sw_pend_we | input | 1 | Software write strobe for the pending bit |
| sw_pend_d | input | 1 | Value written to the pending bit |
| ovf_view | output | 32 | Masked supervisor overflow view |
| lcof_pend | output | 1 | Shared count-overflow pending bit (interrupt-pending bit 13) |

## Verification
Two functions can act on the pending bit in the same cycle: a hardware request from a counter and a software write that clears the bit. The bench applies a request on counter 31 and a zero-write in the same drive window. It then requires the bit to read 1 after the edge, and it checks separately that a lone zero-write does clear the bit. The view is swept over all eight privilege codes with generated flag and enable patterns, and each result is compared with a mask that the bench computes itself.

// File: rtl/ovf_agg_pkg.sv
package ovf_agg_pkg;
   typedef enum logic [2:0] {
      PRV_USER   = 3'b000,
      PRV_SUPER  = 3'b001,
      PRV_MACH   = 3'b011,
      PRV_VUSER  = 3'b100,
      PRV_VSUPER = 3'b101
   } priv_e;

   // Which enable masks gate the overflow view
   typedef enum logic [1:0] {
      VIS_NONE = 2'd0,
      VIS_MACH = 2'd1,
      VIS_BOTH = 2'd2
   } vis_e;

   function automatic vis_e vis_of(input logic [2:0] p);
      vis_e v;
      case (p)
         PRV_MACH, PRV_SUPER: v = VIS_MACH;
         PRV_VSUPER:          v = VIS_BOTH;
         default:             v = VIS_NONE;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/ovf_vis_decode.sv
module ovf_vis_decode
   import ovf_agg_pkg::*;
(
   input  logic [2:0] priv_mode,
   output vis_e       vis
);
   always_comb vis = vis_of(priv_mode);
endmodule

// File: rtl/ovf_view_mask.sv
module ovf_view_mask
   import ovf_agg_pkg::*;
#(
   parameter int VIEW_W    = 32,
   parameter int FIRST_CTR = 3
) (
   input  vis_e                        vis,
   input  logic [VIEW_W-1:FIRST_CTR]   of_flags,
   input  logic [VIEW_W-1:FIRST_CTR]   mctr_en,
   input  logic [VIEW_W-1:FIRST_CTR]   hctr_en,
   output logic [VIEW_W-1:0]           view
);
   logic show_m;
   logic show_h;

   always_comb begin
      show_m = (vis == VIS_MACH) || (vis == VIS_BOTH);
      show_h = (vis == VIS_BOTH);
   end

   for (genvar b = 0; b < VIEW_W; b++) begin : g_bit
      if (b < FIRST_CTR) begin : g_fixed
         assign view[b] = 1'b0;
      end else begin : g_live
         assign view[b] = of_flags[b] & show_m & mctr_en[b] & (~show_h | hctr_en[b]);
      end
   end
endmodule

// File: rtl/lcof_pend_reg.sv
module lcof_pend_reg #(
   parameter int VIEW_W    = 32,
   parameter int FIRST_CTR = 3,
   parameter bit HAS_LCOF  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [VIEW_W-1:FIRST_CTR]   ovf_req,
   input  logic                        sw_we,
   input  logic                        sw_d,
   output logic                        pend
);
   if (HAS_LCOF) begin : g_present
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_q <= 1'b0;
         else if (|ovf_req)   pend_q <= 1'b1;   // hardware set has priority
         else if (sw_we)      pend_q <= sw_d;
      end
      assign pend = pend_q;
   end else begin : g_absent
      assign pend = 1'b0;
   end
endmodule

// File: rtl/ovf_view_agg.sv
module ovf_view_agg
   import ovf_agg_pkg::*;
#(
   parameter int VIEW_W    = 32,
   parameter int FIRST_CTR = 3,
   parameter bit HAS_LCOF  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [2:0]                  priv_mode,
   input  logic [VIEW_W-1:FIRST_CTR]   of_flags,
   input  logic [VIEW_W-1:FIRST_CTR]   ovf_req,
   input  logic [VIEW_W-1:FIRST_CTR]   mctr_en,
   input  logic [VIEW_W-1:FIRST_CTR]   hctr_en,
   input  logic                        sw_pend_we,
   input  logic                        sw_pend_d,
   output logic [VIEW_W-1:0]           ovf_view,
   output logic                        lcof_pend
);
   if (FIRST_CTR < 1 || FIRST_CTR >= VIEW_W) begin : g_bad_first
      $error("ovf_view_agg: FIRST_CTR must lie in 1..VIEW_W-1");
   end
   if (VIEW_W > 64) begin : g_bad_width
      $error("ovf_view_agg: VIEW_W above 64 is not supported");
   end

   vis_e vis;

   ovf_vis_decode i_dec (
      .priv_mode (priv_mode),
      .vis       (vis)
   );

   ovf_view_mask #(.VIEW_W(VIEW_W), .FIRST_CTR(FIRST_CTR)) i_mask (
      .vis      (vis),
      .of_flags (of_flags),
      .mctr_en  (mctr_en),
      .hctr_en  (hctr_en),
      .view     (ovf_view)
   );

   lcof_pend_reg #(.VIEW_W(VIEW_W), .FIRST_CTR(FIRST_CTR), .HAS_LCOF(HAS_LCOF)) i_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovf_req (ovf_req),
      .sw_we   (sw_pend_we),
      .sw_d    (sw_pend_d),
      .pend    (lcof_pend)
   );
endmodule

// File: rtl/ovf_agg_chk.sv
module ovf_agg_chk #(
   parameter int VIEW_W    = 32,
   parameter int FIRST_CTR = 3,
   parameter bit HAS_LCOF  = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [2:0]                  priv_mode,
   input logic [VIEW_W-1:FIRST_CTR]   mctr_en,
   input logic [VIEW_W-1:FIRST_CTR]   hctr_en,
   input logic [VIEW_W-1:FIRST_CTR]   ovf_req,
   input logic                        sw_pend_we,
   input logic                        sw_pend_d,
   input logic [VIEW_W-1:0]           ovf_view,
   input logic                        lcof_pend
);
   logic [VIEW_W-1:0] m_full, mh_full;
   assign m_full  = {mctr_en, {FIRST_CTR{1'b0}}};
   assign mh_full = {mctr_en & hctr_en, {FIRST_CTR{1'b0}}};

   a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_view[FIRST_CTR-1:0] == '0);

   a_r4_user_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode != 3'b011 && priv_mode != 3'b001 && priv_mode != 3'b101) |-> ovf_view == '0);

   a_r2_mach_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 3'b011 || priv_mode == 3'b001) |-> (ovf_view & ~m_full) == '0);

   a_r3_virt_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 3'b101) |-> (ovf_view & ~mh_full) == '0);

   a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LCOF && |ovf_req) |=> lcof_pend);

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LCOF && |ovf_req && sw_pend_we && !sw_pend_d) |=> lcof_pend);

   a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pend_we && !sw_pend_d && ovf_req == '0) |=> !lcof_pend);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_pend_we && ovf_req == '0) |=> $stable(lcof_pend));

   a_r10_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_LCOF |-> !lcof_pend);
endmodule

bind ovf_view_agg ovf_agg_chk #(.VIEW_W(VIEW_W), .FIRST_CTR(FIRST_CTR), .HAS_LCOF(HAS_LCOF)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .priv_mode  (priv_mode),
   .mctr_en    (mctr_en),
   .hctr_en    (hctr_en),
   .ovf_req    (ovf_req),
   .sw_pend_we (sw_pend_we),
   .sw_pend_d  (sw_pend_d),
   .ovf_view   (ovf_view),
   .lcof_pend  (lcof_pend)
);

// File: tb/test_ovf_view_agg.sv
`timescale 1ns/1ps
module test_ovf_view_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  priv_mode = 3'b011;
   logic [31:3] of_flags = '0, ovf_req = '0, mctr_en = '0, hctr_en = '0;
   logic        sw_pend_we = 1'b0, sw_pend_d = 1'b0;
   logic [31:0] ovf_view, view_abs;
   logic        lcof_pend, pend_abs;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] rng = 32'h1234_5677;

   always #2 clk = ~clk;

   ovf_view_agg i_ovf_view_agg (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .of_flags(of_flags),
      .ovf_req(ovf_req), .mctr_en(mctr_en), .hctr_en(hctr_en),
      .sw_pend_we(sw_pend_we), .sw_pend_d(sw_pend_d),
      .ovf_view(ovf_view), .lcof_pend(lcof_pend));

   ovf_view_agg #(.HAS_LCOF(1'b0)) i_ovf_view_agg_absent (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .of_flags(of_flags),
      .ovf_req(ovf_req), .mctr_en(mctr_en), .hctr_en(hctr_en),
      .sw_pend_we(sw_pend_we), .sw_pend_d(sw_pend_d),
      .ovf_view(view_abs), .lcof_pend(pend_abs));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #800000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      step();
      check(lcof_pend == 1'b0, "R9 reset", {31'b0, lcof_pend}, 32'h0);
      step();
      rst_n = 1'b1;
      step();

      // view sweep across every privilege code
      for (int p = 0; p < 8; p++) begin
         for (int k = 0; k < 6; k++) begin
            logic [31:0] a, m, h, exp;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); m = (k == 0) ? 32'hFFFF_FFFF : rng;
            rng = next_rng(rng); h = (k == 1) ? 32'hFFFF_FFFF : rng;
            priv_mode = p[2:0];
            of_flags = a[31:3]; mctr_en = m[31:3]; hctr_en = h[31:3];
            #1;
            case (p)
               3, 1:    exp = a & m;
               5:       exp = a & m & h;
               default: exp = 32'h0;
            endcase
            exp[2:0] = 3'b000;
            if (p == 3 && k == 0)
               check(ovf_view == {a[31:3], 3'b000}, "R1 mirror", ovf_view, {a[31:3], 3'b000});
            else if (p == 3 || p == 1)
               check(ovf_view == exp, "R2 machine mask", ovf_view, exp);
            else if (p == 5)
               check(ovf_view == exp, "R3 virtual mask", ovf_view, exp);
            else
               check(ovf_view == exp, "R4 dark mode", ovf_view, exp);
            check(ovf_view[2:0] == 3'b000, "R5 low bits", {29'b0, ovf_view[2:0]}, 32'h0);
            step();
         end
      end

      // pending bit sequencing
      ovf_req = '0; ovf_req[7] = 1'b1;
      step();
      ovf_req = '0;
      check(lcof_pend == 1'b1, "R6 request sets", {31'b0, lcof_pend}, 32'h1);
      check(pend_abs == 1'b0, "R10 absent", {31'b0, pend_abs}, 32'h0);
      step();
      check(lcof_pend == 1'b1, "R9 hold", {31'b0, lcof_pend}, 32'h1);
      sw_pend_we = 1'b1; sw_pend_d = 1'b0;
      step();
      check(lcof_pend == 1'b0, "R7 write clears", {31'b0, lcof_pend}, 32'h0);
      ovf_req[31] = 1'b1;
      step();
      ovf_req = '0;
      check(lcof_pend == 1'b1, "R8 set beats clear", {31'b0, lcof_pend}, 32'h1);
      check(pend_abs == 1'b0, "R10 absent", {31'b0, pend_abs}, 32'h0);
      step();
      check(lcof_pend == 1'b0, "R7 write clears", {31'b0, lcof_pend}, 32'h0);
      sw_pend_d = 1'b1;
      step();
      sw_pend_we = 1'b0; sw_pend_d = 1'b0;
      check(lcof_pend == 1'b1, "R7 write sets", {31'b0, lcof_pend}, 32'h1);
      check(pend_abs == 1'b0, "R10 absent", {31'b0, pend_abs}, 32'h0);
      step();
      check(lcof_pend == 1'b1, "R9 hold", {31'b0, lcof_pend}, 32'h1);
      finish_run();
   end
endmodule